// File: doc/BRIEF.md
# Real-Time Clock Status Flags and Interrupt Request

This block keeps the eight event flags of a real-time clock together with the interrupt request they drive. Each flag is set by its own event. Seven of these events are single-cycle tick strobes: chronograph, day, hour, minute, second and two time-base rates. The eighth, the alarm, is the rising edge of a comparison between the running hour/minute counters and the alarm hour/minute settings. A flag stays set until software clears it with a two-step read. The first step reads the status register while the flag is 1. The second step reads the data register that belongs to that flag.

Each flag is held by a small state machine with three states:
- `FL_CLEAR`: the flag is 0.
- `FL_SET`: the flag is 1 but not yet armed for clearing.
- `FL_ARMED`: the flag is 1 and has been seen by a status read.

The transitions are:
- *set*: `FL_CLEAR` to `FL_SET` on the flag's event.
- *arm*: `FL_SET` to `FL_ARMED` on a status read.
- *clear*: `FL_ARMED` to `FL_CLEAR` on a read of the flag's data register.
- *reset-set*: `FL_ARMED` to `FL_SET` when that data read meets a new event in the same cycle.

Every other combination keeps the current state.

Reads are presented on a simple bus with a read strobe and an address. The status value comes back on the read-data port one cycle after the strobe, and any other address returns zero. The interrupt request is the registered OR, over all eight flags, of each flag ANDed with its enable bit.

Top module: `rtc_status_flags`

## Requirements
- R1: A read at address 0 returns the flags one cycle later with alarm in bit 7, then chronograph in bit 6, day in bit 5, hour in bit 4, minute in bit 3, second in bit 2, time-base 1 in bit 1 and time-base 2 in bit 0. Any other read, and any cycle without a read, returns 0.
- R2: While reset is asserted, and directly after it, all flags, the read data and the interrupt request are 0.
- R3: A tick strobe that is high at a clock edge sets its flag from that edge on.
- R4: The alarm flag sets on the edge where the hour and minute counters first equal the alarm hour and minute. A match that persists does not set it again after it is cleared.
- R5: A flag clears only after a status read that sees it at 1 is followed by a read of its data register. The data register addresses are 1 for alarm (alarm hour), 2 for chronograph, 3 for day, 4 for hour, 5 for minute, 6 for second, 7 for time-base 1 and 8 for time-base 2.
- R6: A data-register read of a flag that has not been armed leaves the flag at 1.
- R7: A status read that sees a flag at 0 does not arm it, even if the flag's event arrives in that same cycle.
- R8: When a flag's event and its clearing data read fall in the same cycle, the flag stays 1 and is no longer armed.
- R9: The interrupt request equals, one cycle later, the OR over all flags of (flag AND its enable bit).
- R10: Reads of other addresses, including other flags' data registers, neither clear nor disarm an armed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hour_cnt | input | HOUR_W | Running hour counter |
| min_cnt | input | MIN_W | Running minute counter |
| alm_hour | input | HOUR_W | Alarm hour setting |
| alm_min | input | MIN_W | Alarm minute setting |
| chr_tick | input | 1 | Chronograph tick strobe (1/128 s) |
| day_tick | input | 1 | Day event strobe |
| hour_tick | input | 1 | Hour event strobe |
| min_tick | input | 1 | Minute event strobe |
| sec_tick | input | 1 | Second event strobe |
| tb1_tick | input | 1 | Time-base 1 strobe |
| tb2_tick | input | 1 | Time-base 2 strobe |
| irq_en | input | 8 | Per-flag interrupt enables, same bit order as the status value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that each read is a single-cycle strobe with one address. This means a status read and a data read can never share a cycle. They also assume that the tick strobes and the counters are synchronous to the clock. The stimulus drives every input on the falling edge and changes the counters only between edges. It exercises simultaneous events and reads through directed sequences. Random phases keep the counters within a small range so that alarm matches rise and fall often, and they mix reads of every mapped address plus one unmapped address.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;

    localparam int NFLAG = 8;

    localparam int BIT_ALM = 7;
    localparam int BIT_CHR = 6;
    localparam int BIT_DAY = 5;
    localparam int BIT_HR  = 4;
    localparam int BIT_MIN = 3;
    localparam int BIT_SEC = 2;
    localparam int BIT_TB1 = 1;
    localparam int BIT_TB2 = 0;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    // Data register address of flag bit b: the alarm sits first, the last time-base last.
    function automatic int data_addr(input int base, input int b);
        return base + (NFLAG - 1 - b);
    endfunction

endpackage

// File: rtl/rtcf_bus_decode.sv
module rtcf_bus_decode
    import rtcf_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int DATA_BASE   = 1
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              status_rd,
    output logic [NFLAG-1:0]  data_rd
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    assign status_rd = rd_en && (rd_addr == STAT_A);

    for (genvar b = 0; b < NFLAG; b++) begin : g_dec
        localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(data_addr(DATA_BASE, b));
        assign data_rd[b] = rd_en && (rd_addr == DATA_A);
    end

endmodule

// File: rtl/rtcf_flag_cell.sv
module rtcf_flag_cell
    import rtcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic status_rd,
    input  logic data_rd,
    output logic flag
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (set_ev) state_d = FL_SET;
            end
            FL_SET: begin
                if (status_rd) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (data_rd) state_d = set_ev ? FL_SET : FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FL_SET) || (state_q == FL_ARMED);
    end

endmodule

// File: rtl/rtcf_alarm_edge.sv
module rtcf_alarm_edge #(
    parameter int HOUR_W = 5,
    parameter int MIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOUR_W-1:0] hour_cnt,
    input  logic [MIN_W-1:0]  min_cnt,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    output logic              rise
);

    logic match;
    logic match_q;

    assign match = (hour_cnt == alm_hour) && (min_cnt == alm_min);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match;
        end
    end

    assign rise = match && !match_q;

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtcf_pkg::*;
#(
    parameter int HOUR_W      = 5,
    parameter int MIN_W       = 6,
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int DATA_BASE   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOUR_W-1:0] hour_cnt,
    input  logic [MIN_W-1:0]  min_cnt,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic              chr_tick,
    input  logic              day_tick,
    input  logic              hour_tick,
    input  logic              min_tick,
    input  logic              sec_tick,
    input  logic              tb1_tick,
    input  logic              tb2_tick,
    input  logic [7:0]        irq_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq
);

    logic             alarm_rise;
    logic             status_rd;
    logic [NFLAG-1:0] data_rd;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] flags_w;

    rtcf_alarm_edge #(
        .HOUR_W (HOUR_W),
        .MIN_W  (MIN_W)
    ) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hour_cnt (hour_cnt),
        .min_cnt  (min_cnt),
        .alm_hour (alm_hour),
        .alm_min  (alm_min),
        .rise     (alarm_rise)
    );

    rtcf_bus_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .DATA_BASE   (DATA_BASE)
    ) u_dec (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .status_rd (status_rd),
        .data_rd   (data_rd)
    );

    always_comb begin
        set_ev          = '0;
        set_ev[BIT_ALM] = alarm_rise;
        set_ev[BIT_CHR] = chr_tick;
        set_ev[BIT_DAY] = day_tick;
        set_ev[BIT_HR]  = hour_tick;
        set_ev[BIT_MIN] = min_tick;
        set_ev[BIT_SEC] = sec_tick;
        set_ev[BIT_TB1] = tb1_tick;
        set_ev[BIT_TB2] = tb2_tick;
    end

    for (genvar b = 0; b < NFLAG; b++) begin : g_flag
        rtcf_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_ev    (set_ev[b]),
            .status_rd (status_rd),
            .data_rd   (data_rd[b]),
            .flag      (flags_w[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            rd_data <= status_rd ? flags_w : '0;
            irq     <= |(flags_w & irq_en);
        end
    end

endmodule

// File: rtl/rtc_status_flags_chk.sv
module rtc_status_flags_chk #(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int DATA_BASE   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        flags,
    input logic [6:0]        ticks,
    input logic [7:0]        irq_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    // R1
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STAT_A) |=> (rd_data == $past(flags)));

    // R1
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == STAT_A) |=> (rd_data == 8'h00));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(flags & irq_en))));

    for (genvar b = 0; b < 7; b++) begin : g_tick
        // R3
        tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ticks[b] |=> flags[b]);
    end

    for (genvar b = 0; b < 8; b++) begin : g_fall
        localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_BASE + 7 - b);
        // R5
        fall_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[b]) |-> $past(rd_en && rd_addr == DATA_A));
    end

endmodule

bind rtc_status_flags rtc_status_flags_chk #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .DATA_BASE   (DATA_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags_w),
    .ticks   ({chr_tick, day_tick, hour_tick, min_tick, sec_tick, tb1_tick, tb2_tick}),
    .irq_en  (irq_en),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/tb_rtc_status_flags.sv
module tb_rtc_status_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] hour_cnt = '0, alm_hour = 5'd7;
    logic [5:0] min_cnt = '0, alm_min = 6'd30;
    logic [6:0] tk = '0;
    logic [7:0] irq_en = '0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rtc_status_flags dut (
        .clk (clk), .rst_n (rst_n),
        .hour_cnt (hour_cnt), .min_cnt (min_cnt),
        .alm_hour (alm_hour), .alm_min (alm_min),
        .chr_tick (tk[6]), .day_tick (tk[5]), .hour_tick (tk[4]),
        .min_tick (tk[3]), .sec_tick (tk[2]), .tb1_tick (tk[1]), .tb2_tick (tk[0]),
        .irq_en (irq_en), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .irq (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: flags and armed bits as plain vectors.
    logic [7:0] m_flag, m_arm, m_rd;
    logic       m_irq, m_prev;
    initial begin m_flag = '0; m_arm = '0; m_rd = '0; m_irq = 0; m_prev = 0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_arm = '0; m_rd = '0; m_irq = 0; m_prev = 0;
        end else begin
            logic       match, srd, drd;
            logic [7:0] setv, nf, na;
            match = (hour_cnt == alm_hour) && (min_cnt == alm_min);
            setv  = {match && !m_prev, tk};
            srd   = rd_en && (rd_addr == 4'd0);
            for (int i = 0; i < 8; i++) begin
                drd   = rd_en && (int'(rd_addr) == 8 - i);
                nf[i] = setv[i] | (m_flag[i] & !(m_arm[i] & drd));
                na[i] = (srd & m_flag[i]) | (m_arm[i] & !drd);
            end
            m_irq  = |(m_flag & irq_en);
            m_rd   = srd ? m_flag : 8'h00;
            m_flag = nf;
            m_arm  = na;
            m_prev = match;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(rd_data == 8'h00, "R2 rd_data in reset", rd_data, 0);
                chk(irq == 1'b0, "R2 irq in reset", irq, 0);
            end else begin
                chk(rd_data == m_rd, "R1 rd_data vs model", rd_data, m_rd);
                chk(irq == m_irq, "R9 irq vs model", irq, m_irq);
            end
        end
    end

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; rd_addr = '0; v = rd_data;
    endtask

    task automatic pulse(input int b);
        @(negedge clk); tk[b] = 1'b1;
        @(negedge clk); tk = '0;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 0, "R2 irq after reset", irq, 0);
        rd(4'd0, v); chk(v == 8'h00, "R2 flags after reset", v, 0);

        // R3 / R1 second tick lands in bit 2; R10 other data read keeps arming; R5 clear
        pulse(2);
        rd(4'd0, v); chk(v == 8'h04, "R3 second flag bit 2", v, 8'h04);
        rd(4'd5, v);
        rd(4'd0, v); chk(v == 8'h04, "R10 minute data read kept second", v, 8'h04);
        rd(4'd6, v);
        rd(4'd0, v); chk(v == 8'h00, "R5 second cleared", v, 0);

        // R6 chronograph data read before arming
        pulse(6);
        rd(4'd2, v);
        rd(4'd0, v); chk(v == 8'h40, "R6 unarmed read kept chrono", v, 8'h40);
        rd(4'd2, v);
        rd(4'd0, v); chk(v == 8'h00, "R5 chrono cleared", v, 0);

        // R7 status read of a zero flag does not arm
        rd(4'd0, v);
        pulse(5);
        rd(4'd3, v);
        rd(4'd0, v); chk(v == 8'h20, "R7 day flag not armed by earlier read", v, 8'h20);
        rd(4'd3, v);
        rd(4'd0, v); chk(v == 8'h00, "R5 day cleared", v, 0);

        // R8 set and clearing read in the same cycle
        pulse(4);
        rd(4'd0, v); chk(v == 8'h10, "R3 hour flag bit 4", v, 8'h10);
        @(negedge clk); rd_en = 1'b1; rd_addr = 4'd4; tk[4] = 1'b1;
        @(negedge clk); rd_en = 1'b0; rd_addr = '0; tk = '0;
        rd(4'd0, v); chk(v == 8'h10, "R8 set wins over clear", v, 8'h10);
        rd(4'd4, v);
        rd(4'd0, v); chk(v == 8'h00, "R5 hour cleared", v, 0);

        // R4 alarm on the rising edge of the match
        @(negedge clk); hour_cnt = 5'd7; min_cnt = 6'd30;
        @(negedge clk);
        rd(4'd0, v); chk(v == 8'h80, "R4 alarm set on match", v, 8'h80);
        rd(4'd1, v);
        rd(4'd0, v); chk(v == 8'h00, "R4 held match does not re-set", v, 0);
        @(negedge clk); min_cnt = 6'd31;
        @(negedge clk); min_cnt = 6'd30;
        @(negedge clk);
        rd(4'd0, v); chk(v == 8'h80, "R4 new match sets again", v, 8'h80);
        rd(4'd1, v);
        @(negedge clk); hour_cnt = 5'd0; min_cnt = 6'd0;

        // R9 interrupt latency and enable masking
        @(negedge clk); irq_en = 8'h02; tk[1] = 1'b1;
        @(negedge clk); tk = '0;
        chk(irq == 0, "R9 irq one edge after set", irq, 0);
        @(negedge clk);
        chk(irq == 1, "R9 irq raised", irq, 1);
        irq_en = 8'h01;
        @(negedge clk);
        chk(irq == 0, "R9 irq masked", irq, 0);
        rd(4'd0, v); chk(v == 8'h02, "R1 tb1 in bit 1", v, 8'h02);
        rd(4'd7, v);
        rd(4'd0, v); chk(v == 8'h00, "R5 tb1 cleared", v, 0);

        // Random phase, compared against the model every cycle
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            for (int i = 0; i < 7; i++) tk[i] = ($urandom % 8) == 0;
            rd_en   = ($urandom % 2) == 0;
            rd_addr = 4'($urandom % 10);
            if ($urandom % 16 == 0) irq_en = 8'($urandom);
            if ($urandom % 6 == 0) begin
                hour_cnt = 5'd6 + 5'($urandom % 2);
                min_cnt  = 6'd29 + 6'($urandom % 2);
            end
        end
        @(negedge clk); tk = '0; rd_en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule